// File: doc/BRIEF.md
# Microcoded Memory Strobe Sequencer

This block produces the chip-select and byte-lane strobes for an external memory from a small microcode store that software can write. The store holds 64 words of 32 bits. A host points an index register at one entry, then writes that entry or reads it back. Each word describes one memory clock cycle. The cycle is split into four equal phases, T1 to T4, and each phase lasts one period of the block's clock, which runs at four times the memory rate. For every phase the word gives the chip-select level and the byte-select level.

A start pulse carries a 6-bit entry index and launches a sequence at that entry. The engine then plays the words in order, four phases per word, until it finishes a word marked as last. At start it also captures which byte lanes the access uses. That choice comes from the port width, the transfer size and the three low address bits. Lanes outside the access stay high whatever the microcode asks for.

Top module: `mseq_top`

## Requirements
- R1: The store holds 64 words of 32 bits. A value written to an entry through the host data port is returned on the host read port whenever the index register points at that entry.
- R2: The host index register is 6 bits wide, is loaded by `host_sel_we`, and selects the entry used by both host write and host read.
- R3: A `seq_start` pulse seen while idle begins a sequence at `seq_start_idx`. `seq_busy` is high from the cycle after that edge until the last word's fourth phase has ended.
- R4: Every word occupies exactly four consecutive clock cycles. In the k-th of these cycles (k = 0..3), `cs_n` equals bit k of the word.
- R5: In the k-th phase of a word, each selected byte lane drives bit 4+k of the word on `bs_n`.
- R6: `port_size` codes 0..3 mean 1, 2, 4 or 8 lanes, and `xfer_size` codes 0..3 mean 1, 2, 4 or 8 bytes. The offset is `addr_lo` modulo the lane count. Lane i is selected when offset <= i < offset + bytes and i < lane count. Unselected lanes are held high. The selection is captured at start.
- R7: Bit 31 marks the last word. A word without it is followed by the next entry, and entry 63 is followed by entry 0.
- R8: After reset and whenever idle, `seq_busy` is low and `cs_n` and every `bs_n` lane are high.
- R9: Host writes to the store are ignored while a sequence is running.
- R10: A `seq_start` pulse during a running sequence is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, four times the memory clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel_we | input | 1 | Load the host index register |
| host_sel_idx | input | 6 | New host index value |
| host_word_we | input | 1 | Write host data into the indexed entry |
| host_word_wdata | input | 32 | Microinstruction to store |
| host_word_rdata | output | 32 | Contents of the indexed entry |
| seq_start | input | 1 | Launch a sequence |
| seq_start_idx | input | 6 | First entry of the sequence |
| port_size | input | 2 | Port width code (1, 2, 4 or 8 lanes) |
| xfer_size | input | 2 | Transfer size code (1, 2, 4 or 8 bytes) |
| addr_lo | input | 3 | Low address bits of the access |
| seq_busy | output | 1 | A sequence is running |
| cs_n | output | 1 | Chip select, active low |
| bs_n | output | 8 | Byte-lane selects, active low |

## Verification
The bench plays a three-word sequence that crosses from entry 63 to entry 0. A design that fails to wrap the pointer, or that stops early, shows the wrong strobe levels or drops busy too soon. Lane selection is driven through misaligned cases: a transfer clipped at the port edge, a one-lane port with a large offset address, and a top-lane-only access. A mask that ignores the port width or wraps lanes around would drive a lane that should stay high. While a sequence runs, the bench issues a host write and a second start. A store that accepts the write would later read back the corrupted word, and an engine that accepts the start would stay busy beyond four cycles. Each phase is compared cycle by cycle, so an off-by-one phase order or a missing pipeline stage shows up as a shifted waveform.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    localparam int unsigned NUM_PHASES = 4;
    localparam int unsigned PHASE_W    = $clog2(NUM_PHASES);
    localparam int unsigned CS_BASE    = 0;
    localparam int unsigned BS_BASE    = 4;
    localparam int unsigned LAST_BIT   = 31;
endpackage

// File: rtl/mseq_ucode_store.sv
module mseq_ucode_store #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_i,
    input  logic              sel_we_i,
    input  logic [ADDR_W-1:0] sel_idx_i,
    input  logic              word_we_i,
    input  logic [WORD_W-1:0] word_wdata_i,
    output logic [WORD_W-1:0] host_rdata_o,
    input  logic [ADDR_W-1:0] seq_ptr_i,
    output logic [WORD_W-1:0] seq_word_o
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] sel_d, sel_q;
    logic              wr_en;

    always_comb begin
        sel_d = sel_q;
        if (sel_we_i) sel_d = sel_idx_i;
        wr_en = word_we_i && !lock_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    // Store contents are left unreset on purpose.
    always_ff @(posedge clk) begin
        if (wr_en) mem[sel_q] <= word_wdata_i;
    end

    assign host_rdata_o = mem[sel_q];
    assign seq_word_o   = mem[seq_ptr_i];

    // R9: a write attempted while locked leaves the indexed word untouched
    assert_locked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && !sel_we_i) |=> $stable(host_rdata_o));
endmodule

// File: rtl/mseq_lane_sel.sv
module mseq_lane_sel #(
    parameter int unsigned LANES = 8,
    localparam int unsigned OFF_W  = $clog2(LANES),
    localparam int unsigned SIZE_W = $clog2(OFF_W + 1)
) (
    input  logic [SIZE_W-1:0] port_size_i,
    input  logic [SIZE_W-1:0] xfer_size_i,
    input  logic [OFF_W-1:0]  addr_lo_i,
    output logic [LANES-1:0]  sel_o
);
    int unsigned n_lanes, n_bytes, offset;

    always_comb begin
        n_lanes = 32'd1 << port_size_i;
        if (n_lanes > LANES) n_lanes = LANES;
        n_bytes = 32'd1 << xfer_size_i;
        offset  = 32'(addr_lo_i) & (n_lanes - 32'd1);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int unsigned IDX = g;
        assign sel_o[g] = (IDX < n_lanes) && (IDX >= offset) && (IDX < offset + n_bytes);
    end
endmodule

// File: rtl/mseq_phase_engine.sv
module mseq_phase_engine
    import mseq_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned LANES  = 8,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_idx_i,
    input  logic [LANES-1:0]  lane_sel_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              busy_o,
    output logic              cs_n_o,
    output logic [LANES-1:0]  bs_n_o
);
    typedef struct packed {
        logic               run;
        logic [PHASE_W-1:0] phase;
        logic [ADDR_W-1:0]  ptr;
        logic [LANES-1:0]   mask;
    } eng_t;

    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(NUM_PHASES - 1);

    eng_t st_d, st_q;
    logic cs_lvl, bs_lvl;

    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            if (start_i) begin
                st_d.run   = 1'b1;
                st_d.phase = '0;
                st_d.ptr   = start_idx_i;
                st_d.mask  = lane_sel_i;
            end
        end else if (st_q.phase == LAST_PHASE) begin
            st_d.phase = '0;
            if (word_i[LAST_BIT]) st_d.run = 1'b0;
            else                  st_d.ptr = st_q.ptr + 1'b1;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cs_lvl = word_i[CS_BASE + 32'(st_q.phase)];
        bs_lvl = word_i[BS_BASE + 32'(st_q.phase)];
    end

    assign ptr_o  = st_q.ptr;
    assign busy_o = st_q.run;
    assign cs_n_o = st_q.run ? cs_lvl : 1'b1;

    for (genvar g = 0; g < LANES; g++) begin : g_bs
        assign bs_n_o[g] = (st_q.run && st_q.mask[g]) ? bs_lvl : 1'b1;
    end

    // R4: phases step one per clock inside a word
    assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.phase != LAST_PHASE) |=>
            (st_q.run && st_q.phase == PHASE_W'($past(st_q.phase) + 1'b1)));

    // R7: the last flag returns the engine to idle after T4
    assert_last_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.phase == LAST_PHASE && word_i[LAST_BIT]) |=> !st_q.run);

    // R7: without the last flag the next entry follows, wrapping at the top
    assert_ptr_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.phase == LAST_PHASE && !word_i[LAST_BIT]) |=>
            (st_q.run && st_q.phase == '0 && st_q.ptr == ADDR_W'($past(st_q.ptr) + 1'b1)));
endmodule

// File: rtl/mseq_top.sv
module mseq_top #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned LANES  = 8,
    localparam int unsigned ADDR_W = $clog2(DEPTH),
    localparam int unsigned OFF_W  = $clog2(LANES),
    localparam int unsigned SIZE_W = $clog2(OFF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel_we,
    input  logic [ADDR_W-1:0] host_sel_idx,
    input  logic              host_word_we,
    input  logic [WORD_W-1:0] host_word_wdata,
    output logic [WORD_W-1:0] host_word_rdata,
    input  logic              seq_start,
    input  logic [ADDR_W-1:0] seq_start_idx,
    input  logic [SIZE_W-1:0] port_size,
    input  logic [SIZE_W-1:0] xfer_size,
    input  logic [OFF_W-1:0]  addr_lo,
    output logic              seq_busy,
    output logic              cs_n,
    output logic [LANES-1:0]  bs_n
);
    logic [ADDR_W-1:0] ptr;
    logic [WORD_W-1:0] cur_word;
    logic [LANES-1:0]  lane_sel;

    mseq_ucode_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .lock_i       (seq_busy),
        .sel_we_i     (host_sel_we),
        .sel_idx_i    (host_sel_idx),
        .word_we_i    (host_word_we),
        .word_wdata_i (host_word_wdata),
        .host_rdata_o (host_word_rdata),
        .seq_ptr_i    (ptr),
        .seq_word_o   (cur_word)
    );

    mseq_lane_sel #(.LANES(LANES)) u_lanes (
        .port_size_i (port_size),
        .xfer_size_i (xfer_size),
        .addr_lo_i   (addr_lo),
        .sel_o       (lane_sel)
    );

    mseq_phase_engine #(.DEPTH(DEPTH), .WORD_W(WORD_W), .LANES(LANES)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (seq_start),
        .start_idx_i (seq_start_idx),
        .lane_sel_i  (lane_sel),
        .word_i      (cur_word),
        .ptr_o       (ptr),
        .busy_o      (seq_busy),
        .cs_n_o      (cs_n),
        .bs_n_o      (bs_n)
    );

    // R8: strobes stay inactive whenever no sequence runs
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_busy |-> (cs_n && (&bs_n)));
endmodule

// File: tb/mseq_top_tb_top.sv
`timescale 1ns/1ps
module mseq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel_we = 1'b0;
    logic [5:0]  host_sel_idx = '0;
    logic        host_word_we = 1'b0;
    logic [31:0] host_word_wdata = '0;
    logic [31:0] host_word_rdata;
    logic        seq_start = 1'b0;
    logic [5:0]  seq_start_idx = '0;
    logic [1:0]  port_size = '0;
    logic [1:0]  xfer_size = '0;
    logic [2:0]  addr_lo = '0;
    logic        seq_busy;
    logic        cs_n;
    logic [7:0]  bs_n;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] shadow [64];

    always #2.5 clk = ~clk;

    mseq_top dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] lane_mask(input int ps, input int xs, input int al);
        int nl = 1 << ps;
        int nb = 1 << xs;
        int off = al % nl;
        logic [7:0] m = '0;
        for (int i = 0; i < 8; i++) m[i] = (i < nl) && (i >= off) && (i < off + nb);
        return m;
    endfunction

    task automatic put_word(input int idx, input logic [31:0] d);
        host_sel_we = 1'b1; host_sel_idx = 6'(idx);
        @(negedge clk);
        host_sel_we = 1'b0; host_word_we = 1'b1; host_word_wdata = d;
        @(negedge clk);
        host_word_we = 1'b0;
        shadow[idx] = d;
    endtask

    task automatic read_back(input int idx, input string req);
        host_sel_we = 1'b1; host_sel_idx = 6'(idx);
        @(negedge clk);
        host_sel_we = 1'b0;
        chk(req, host_word_rdata, shadow[idx]);
    endtask

    // Runs a sequence and compares every phase; optional poke during word 0.
    task automatic run_seq(input int first, input int nwords, input int ps, input int xs,
                           input int al, input bit poke, input string req);
        logic [7:0] m = lane_mask(ps, xs, al);
        port_size = 2'(ps); xfer_size = 2'(xs); addr_lo = 3'(al);
        seq_start = 1'b1; seq_start_idx = 6'(first);
        @(negedge clk);
        seq_start = 1'b0;
        for (int w = 0; w < nwords; w++) begin
            logic [31:0] word = shadow[(first + w) % 64];
            for (int p = 0; p < 4; p++) begin
                logic [7:0] exp_bs;
                for (int i = 0; i < 8; i++) exp_bs[i] = m[i] ? word[4 + p] : 1'b1;
                chk({req, " R3 busy"}, 32'(seq_busy), 32'd1);
                chk({req, " R4 cs_n"}, 32'(cs_n), 32'(word[p]));
                chk({req, " R5/R6 bs_n"}, 32'(bs_n), 32'(exp_bs));
                if (poke && w == 0 && p == 1) begin
                    host_word_we = 1'b1; host_word_wdata = 32'h0000_0000;
                    seq_start = 1'b1; seq_start_idx = 6'd0;
                end else begin
                    host_word_we = 1'b0; seq_start = 1'b0;
                end
                @(negedge clk);
            end
        end
        chk({req, " R3 busy end"}, 32'(seq_busy), 32'd0);
        chk({req, " R8 idle cs_n"}, 32'(cs_n), 32'd1);
        chk({req, " R8 idle bs_n"}, 32'(bs_n), 32'hFF);
    endtask

    task automatic t_reset;
        chk("R8 reset busy", 32'(seq_busy), 32'd0);
        chk("R8 reset cs_n", 32'(cs_n), 32'd1);
        chk("R8 reset bs_n", 32'(bs_n), 32'hFF);
    endtask

    task automatic t_store;
        put_word(5, 32'hDEAD_BEEF);
        put_word(6, 32'h1234_5678);
        put_word(63, 32'hA5A5_0F0F);
        read_back(5, "R1 store 5");
        read_back(63, "R2 store 63");
        read_back(6, "R1 store 6");
    endtask

    task automatic t_single;
        put_word(10, 32'h8000_0069);
        run_seq(10, 1, 3, 3, 0, 1'b0, "single");
    endtask

    task automatic t_wrap;
        put_word(62, 32'h0000_00A5);
        put_word(63, 32'h03C0_003C);
        put_word(0, 32'h8000_00F0);
        run_seq(62, 3, 2, 2, 0, 1'b0, "R7 wrap");
    endtask

    task automatic t_multi;
        put_word(0, 32'h03C0_001E);
        put_word(1, 32'h0000_00E1);
        put_word(2, 32'h0000_0077);
        put_word(3, 32'h8000_0088);
        run_seq(0, 4, 2, 1, 2, 1'b0, "R7 multi");
    endtask

    task automatic t_lanes;
        put_word(30, 32'h8000_00A0);
        run_seq(30, 1, 0, 3, 5, 1'b0, "R6 narrow port");
        run_seq(30, 1, 2, 3, 3, 1'b0, "R6 clipped");
        run_seq(30, 1, 3, 1, 7, 1'b0, "R6 top lane");
        run_seq(30, 1, 3, 2, 6, 1'b0, "R6 upper pair");
    endtask

    task automatic t_lock;
        put_word(20, 32'h8000_005A);
        run_seq(20, 1, 3, 3, 0, 1'b1, "R9 R10 lock");
        chk("R9 write ignored", host_word_rdata, 32'h8000_005A);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store();
        t_single();
        t_wrap();
        t_multi();
        t_lanes();
        t_lock();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule